// File: doc/BRIEF.md
# Saturating Q-Format Arithmetic Unit

This unit sits in the execute stage of a DSP-capable integer pipeline. It performs four signed saturating operations on two register operands. The operations are plain add, plain subtract, doubling add and doubling subtract. Each result is clamped to the signed range of the data width instead of wrapping around. A sticky saturation flag records that clipping has happened at some point. It stays set until software writes it. The unit never touches the N, Z, C or V condition flags; it has no port for them.

An instruction word arrives together with the two operand values. The issue stage drives an issue strobe. An external condition evaluator drives a condition-passed strobe. The unit decodes the word, computes the clamped result, and registers it. The result and its valid strobe appear one clock after issue, along with the destination register index taken from the word. A word that matches no supported encoding raises an undefined-operation pulse in place of a result.

The doubling forms clamp twice. First the second operand is doubled and clamped. Then the add or subtract is clamped again. Either clip sets the flag. A typical use is a Q15 x Q15 product added to itself, which gives a Q31 value and clips only for the single full-scale negative case.

Top module: `satq_unit`

## Requirements
- R1: When the plain add executes (word bits 27:20 = 8'h10), resData one cycle later equals opA + opB clamped to [-2^31, 2^31-1]. For example, 0x40000000 + 0x40000000 gives 0x7FFFFFFF.
- R2: When the plain subtract executes (bits 27:20 = 8'h12), resData equals opA - opB clamped to the same range.
- R3: When the doubling add executes (bits 27:20 = 8'h14), resData equals opA + clamp(2*opB), clamped again.
- R4: When the doubling subtract executes (bits 27:20 = 8'h16), resData equals opA - clamp(2*opB), clamped again.
- R5: An executed operation sets qFlag if any clamp stage clipped. qFlag is sticky: no arithmetic result ever clears it.
- R6: When qWrEn is high at a clock edge, qFlag takes qWrData. This write has priority over a saturation in the same cycle.
- R7: An issue with condPass low produces no resValid and no undefOp, and leaves qFlag unchanged.
- R8: An executed operation raises resValid for exactly the one cycle after issue. resDest equals word bits 15:12.
- R9: A word is legal only if bits 7:4 = 4'b0101 and bits 27:20 hold one of the four codes above. An issued illegal word with condPass high pulses undefOp for one cycle, with no resValid and no change to qFlag.
- R10: During and right after reset, resValid, undefOp and qFlag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| condPass | input | 1 | The external evaluator passed the condition |
| instrWord | input | 32 | Instruction word |
| opA | input | DATA_W | First operand (register named by bits 3:0) |
| opB | input | DATA_W | Second operand (register named by bits 19:16) |
| qWrEn | input | 1 | Software write of the saturation flag |
| qWrData | input | 1 | Value to write into the saturation flag |
| resData | output | DATA_W | Clamped result |
| resDest | output | 4 | Destination register index |
| resValid | output | 1 | Result valid, one cycle after issue |
| undefOp | output | 1 | Undefined-operation pulse |
| qFlag | output | 1 | Sticky saturation flag |

## Verification
A wrong clamp boundary or a missing second clamp stage appears on resData in the cycle after the issue, but only for operands near full scale. The sweep therefore concentrates on the extreme and half-scale values. A flag that is lost or set wrongly only becomes visible through qFlag on that same edge. For that reason the flag is cleared before every operation and compared after it. A decode fault appears as a swapped resValid/undefOp pulse one cycle after issue.

// File: rtl/satq_pkg.sv
package satq_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_DADD = 3'd2,
    OP_DSUB = 3'd3,
    OP_BAD  = 3'd4
  } satOp_e;

  localparam logic [7:0] CODE_ADD  = 8'h10;
  localparam logic [7:0] CODE_SUB  = 8'h12;
  localparam logic [7:0] CODE_DADD = 8'h14;
  localparam logic [7:0] CODE_DSUB = 8'h16;
  localparam logic [3:0] CODE_TAIL = 4'b0101;

  typedef struct packed {
    logic fire;
    logic doubleB;
    logic subtract;
  } satCtrl_t;
endpackage

// File: rtl/satq_ctrl.sv
module satq_ctrl
  import satq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic        condPass,
  input  logic [31:0] instrWord,
  input  logic        qWrEn,
  input  logic        qWrData,
  input  logic        satHit,
  output satCtrl_t    ctrlStb,
  output logic        resValid,
  output logic        undefOp,
  output logic        qFlag
);
  satOp_e opKind;
  logic   takeIt;
  logic   fireNow;
  logic   undefNow;

  always_comb begin
    opKind = OP_BAD;
    if (instrWord[7:4] == CODE_TAIL) begin
      case (instrWord[27:20])
        CODE_ADD:  opKind = OP_ADD;
        CODE_SUB:  opKind = OP_SUB;
        CODE_DADD: opKind = OP_DADD;
        CODE_DSUB: opKind = OP_DSUB;
        default:   opKind = OP_BAD;
      endcase
    end
  end

  assign takeIt   = issueValid & condPass;
  assign fireNow  = takeIt & (opKind != OP_BAD);
  assign undefNow = takeIt & (opKind == OP_BAD);

  always_comb begin
    ctrlStb.fire     = fireNow;
    ctrlStb.doubleB  = (opKind == OP_DADD) || (opKind == OP_DSUB);
    ctrlStb.subtract = (opKind == OP_SUB) || (opKind == OP_DSUB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      undefOp  <= 1'b0;
      qFlag    <= 1'b0;
    end else begin
      resValid <= fireNow;
      undefOp  <= undefNow;
      if (qWrEn)
        qFlag <= qWrData;
      else if (fireNow && satHit)
        qFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/satq_dpath.sv
module satq_dpath
  import satq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  satCtrl_t          ctrlStb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        destIdx,
  output logic              satHit,
  output logic [DATA_W-1:0] resData,
  output logic [3:0]        resDest
);
  localparam int WIDE_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [WIDE_W-1:0] dblWide;
  logic              dblClip;
  logic [DATA_W-1:0] dblClamped;
  logic [DATA_W-1:0] bEff;
  logic [WIDE_W-1:0] aExt;
  logic [WIDE_W-1:0] bExt;
  logic [WIDE_W-1:0] sumWide;
  logic              sumClip;
  logic [DATA_W-1:0] sumClamped;

  // stage one: doubling of the second operand, clamped
  assign dblWide    = {opB, 1'b0};
  assign dblClip    = dblWide[WIDE_W-1] ^ dblWide[WIDE_W-2];
  assign dblClamped = dblClip ? (opB[DATA_W-1] ? MIN_NEG : MAX_POS)
                              : dblWide[DATA_W-1:0];
  assign bEff       = ctrlStb.doubleB ? dblClamped : opB;

  // stage two: add or subtract in one extra bit, then clamp
  assign aExt    = {opA[DATA_W-1], opA};
  assign bExt    = {bEff[DATA_W-1], bEff};
  assign sumWide = ctrlStb.subtract ? (aExt - bExt) : (aExt + bExt);
  assign sumClip = sumWide[WIDE_W-1] ^ sumWide[WIDE_W-2];
  assign sumClamped = sumClip ? (sumWide[WIDE_W-1] ? MIN_NEG : MAX_POS)
                              : sumWide[DATA_W-1:0];

  assign satHit = sumClip | (ctrlStb.doubleB & dblClip);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resDest <= '0;
    end else if (ctrlStb.fire) begin
      resData <= sumClamped;
      resDest <= destIdx;
    end
  end
endmodule

// File: rtl/satq_unit.sv
module satq_unit
  import satq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              condPass,
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              qWrEn,
  input  logic              qWrData,
  output logic [DATA_W-1:0] resData,
  output logic [3:0]        resDest,
  output logic              resValid,
  output logic              undefOp,
  output logic              qFlag
);
  satCtrl_t ctrlStb;
  logic     satHit;

  satq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .condPass   (condPass),
    .instrWord  (instrWord),
    .qWrEn      (qWrEn),
    .qWrData    (qWrData),
    .satHit     (satHit),
    .ctrlStb    (ctrlStb),
    .resValid   (resValid),
    .undefOp    (undefOp),
    .qFlag      (qFlag)
  );

  satq_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlStb (ctrlStb),
    .opA     (opA),
    .opB     (opB),
    .destIdx (instrWord[15:12]),
    .satHit  (satHit),
    .resData (resData),
    .resDest (resDest)
  );
endmodule

// File: rtl/satq_checker.sv
module satq_checker (
  input logic clk,
  input logic rstN,
  input logic issueValid,
  input logic condPass,
  input logic qWrEn,
  input logic qWrData,
  input logic resValid,
  input logic undefOp,
  input logic qFlag
);
  p_q_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (qFlag && !qWrEn) |=> qFlag);

  p_q_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    qWrEn |=> (qFlag == $past(qWrData)));

  p_cond_fail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!condPass && !qWrEn) |=> (!resValid && !undefOp && $stable(qFlag)));

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && condPass) |=> (resValid ^ undefOp));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(issueValid && condPass) |=> (!resValid && !undefOp));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resValid, undefOp}));

  p_undef_noq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (undefOp && !$past(qWrEn)) |-> $stable(qFlag));
endmodule

bind satq_unit satq_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .condPass   (condPass),
  .qWrEn      (qWrEn),
  .qWrData    (qWrData),
  .resValid   (resValid),
  .undefOp    (undefOp),
  .qFlag      (qFlag)
);

// File: tb/satq_unit_tb_top.sv
module satq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic        condPass;
  logic [31:0] instrWord;
  logic [31:0] opA;
  logic [31:0] opB;
  logic        qWrEn;
  logic        qWrData;
  logic [31:0] resData;
  logic [3:0]  resDest;
  logic        resValid;
  logic        undefOp;
  logic        qFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  satq_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .condPass(condPass),
    .instrWord(instrWord), .opA(opA), .opB(opB), .qWrEn(qWrEn),
    .qWrData(qWrData), .resData(resData), .resDest(resDest),
    .resValid(resValid), .undefOp(undefOp), .qFlag(qFlag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] clampS(input longint v);
    if (v > 64'sd2147483647)       return {1'b1, 32'h7FFFFFFF};
    else if (v < -64'sd2147483648) return {1'b1, 32'h80000000};
    else                           return {1'b0, v[31:0]};
  endfunction

  // returns {clip, result}
  function automatic logic [32:0] model(input int opSel, input logic [31:0] a, input logic [31:0] b);
    longint la = longint'($signed(a));
    longint lb = longint'($signed(b));
    logic [32:0] d;
    logic [32:0] r;
    case (opSel)
      0: return clampS(la + lb);
      1: return clampS(la - lb);
      default: begin
        d = clampS(2 * lb);
        if (opSel == 2) r = clampS(la + longint'($signed(d[31:0])));
        else            r = clampS(la - longint'($signed(d[31:0])));
        return {d[32] | r[32], r[31:0]};
      end
    endcase
  endfunction

  function automatic logic [7:0] codeOf(input int opSel);
    case (opSel)
      0: return 8'h10;
      1: return 8'h12;
      2: return 8'h14;
      default: return 8'h16;
    endcase
  endfunction

  function automatic logic [31:0] mkWord(input logic [7:0] code, input logic [3:0] rd, input logic [3:0] tail);
    return {4'hE, code, 4'h2, rd, 4'h0, tail, 4'h1};
  endfunction

  task automatic clearQ(input logic v);
    @(negedge clk);
    issueValid = 1'b0; qWrEn = 1'b1; qWrData = v;
    @(negedge clk);
    qWrEn = 1'b0;
  endtask

  // drive one issue; returns at the negedge after the capturing edge
  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b, input logic cp);
    issueValid = 1'b1; condPass = cp; instrWord = w; opA = a; opB = b;
    @(negedge clk);
    issueValid = 1'b0; condPass = 1'b1;
  endtask

  logic [31:0] vals [12] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                             32'h80000000, 32'h40000000, 32'hC0000000,
                             32'h3FFFFFFF, 32'hBFFFFFFF, 32'h12345678,
                             32'h80000001, 32'hC0000001};

  initial begin
    logic [32:0] e;
    string tag;
    rstN = 1'b0; issueValid = 1'b0; condPass = 1'b1; instrWord = '0;
    opA = '0; opB = '0; qWrEn = 1'b0; qWrData = 1'b0;
    repeat (3) @(negedge clk);
    chk(!resValid && !undefOp && !qFlag, "R10 reset", {29'd0, resValid, undefOp, qFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!resValid && !undefOp && !qFlag, "R10 after reset", {29'd0, resValid, undefOp, qFlag}, 32'd0);

    // sweep: all ops over the corner value set
    for (int op = 0; op < 4; op++) begin
      tag = (op == 0) ? "R1 add" : (op == 1) ? "R2 sub" : (op == 2) ? "R3 dadd" : "R4 dsub";
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          clearQ(1'b0);
          e = model(op, vals[i], vals[j]);
          issue(mkWord(codeOf(op), 4'((i + j) % 16), 4'b0101), vals[i], vals[j], 1'b1);
          chk(resValid && resData == e[31:0], tag, resData, e[31:0]);
          chk(qFlag == e[32], "R5 clip flag", {31'd0, qFlag}, {31'd0, e[32]});
          chk(resDest == 4'((i + j) % 16), "R8 dest", {28'd0, resDest}, 32'((i + j) % 16));
        end
      end
    end

    // R1 Q15 product doubling
    clearQ(1'b0);
    issue(mkWord(8'h10, 4'h3, 4'b0101), 32'h40000000, 32'h40000000, 1'b1);
    chk(resData == 32'h7FFFFFFF && qFlag, "R1 q15 full scale", resData, 32'h7FFFFFFF);

    // R4 positive minus clipped negative double
    clearQ(1'b0);
    issue(mkWord(8'h16, 4'h3, 4'b0101), 32'h00000005, 32'h80000000, 1'b1);
    chk(resData == 32'h7FFFFFFF && qFlag, "R4 pos minus neg double", resData, 32'h7FFFFFFF);

    // R8 single-cycle pulse
    @(negedge clk);
    chk(!resValid, "R8 single pulse", {31'd0, resValid}, 32'd0);

    // R5 sticky across a clean op
    issue(mkWord(8'h10, 4'h1, 4'b0101), 32'd2, 32'd3, 1'b1);
    chk(resData == 32'd5 && qFlag, "R5 sticky", {31'd0, qFlag}, 32'd1);

    // R6 write wins over saturation in same cycle
    qWrEn = 1'b1; qWrData = 1'b0;
    issue(mkWord(8'h10, 4'h1, 4'b0101), 32'h7FFFFFFF, 32'd1, 1'b1);
    qWrEn = 1'b0;
    chk(!qFlag && resData == 32'h7FFFFFFF, "R6 write priority", {31'd0, qFlag}, 32'd0);
    clearQ(1'b1);
    chk(qFlag, "R6 write one", {31'd0, qFlag}, 32'd1);

    // R7 condition fails: nothing happens
    clearQ(1'b0);
    issue(mkWord(8'h14, 4'h1, 4'b0101), 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    chk(!resValid && !undefOp && !qFlag, "R7 cond fail", {29'd0, resValid, undefOp, qFlag}, 32'd0);
    issue(mkWord(8'h18, 4'h1, 4'b0101), 32'd0, 32'd0, 1'b0);
    chk(!undefOp && !resValid, "R7 cond fail undef", {30'd0, resValid, undefOp}, 32'd0);

    // R9 illegal encodings
    clearQ(1'b1);
    issue(mkWord(8'h10, 4'h1, 4'b0110), 32'h7FFFFFFF, 32'd1, 1'b1);
    chk(undefOp && !resValid && qFlag, "R9 bad tail", {29'd0, resValid, undefOp, qFlag}, 32'd3);
    clearQ(1'b0);
    issue(mkWord(8'h18, 4'h1, 4'b0101), 32'h7FFFFFFF, 32'd1, 1'b1);
    chk(undefOp && !resValid && !qFlag, "R9 bad code", {29'd0, resValid, undefOp, qFlag}, 32'd2);
    @(negedge clk);
    chk(!undefOp, "R9 single pulse", {31'd0, undefOp}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule